// File: doc/BRIEF.md
# Dual-Mode Prioritized Interrupt Controller

This block picks one winner from a set of maskable interrupt sources and one non-maskable interrupt, and hands that winner to a CPU core. A mode input selects how the maskable sources are ranked and gated. In fixed mode the sources are ranked by index and are gated by one mask bit. In leveled mode each source carries a programmable 3-bit level and is gated by a 3-bit mask threshold. The non-maskable request is latched on its rising edge. It always outranks every maskable source and ignores both masks.

A source can be accepted only on an instruction-boundary strobe from the core. On acceptance the block pulses an accept output for one cycle and reports the winning source, its level and its vector-table address. It also drives the mask update that the core must apply: in fixed mode it sets the mask bit, and in leveled mode it writes a new mask level. The block does not clear source requests. A source holds its line until its handler services it, so any source that loses arbitration stays pending.

Top module: `irq_dual_mode_ctrl`

## Requirements
- R1: After reset, `ack`, `ack_nmi`, `mask_i_set` and `mask_lvl_wr` are 0, and they stay 0 until the first accepted request.
- R2: A maskable source whose `src_en` bit is 0 is never accepted, even while its `src_req` bit is 1.
- R3: In fixed mode (`mode_sel`=0), while `mask_i`=1, no maskable source is accepted.
- R4: In fixed mode, among the eligible sources the one with the lowest index wins. The programmed levels have no effect in this mode.
- R5: In leveled mode (`mode_sel`=1), a source is eligible only when its 3-bit level, taken from `src_lvl[3*i+2:3*i]`, is strictly greater than `mask_lvl`. In this mode `mask_i` has no effect.
- R6: In leveled mode the highest eligible level wins, and a tie goes to the lowest index. `ack_lvl` reports the winner's level.
- R7: A rising edge on `nmi_req` is latched. The latched request is accepted at the next boundary whatever the mode, `mask_i` or `mask_lvl`, and it outranks all maskable sources. Each edge gives exactly one acceptance, reported with `ack_nmi`=1, `ack_id`=0 and `ack_lvl`=8.
- R8: `ack` pulses for exactly one cycle, in the cycle after an edge at which `insn_done`=1 and some request was eligible. Without `insn_done` nothing is accepted.
- R9: With each `ack` there is exactly one mask update. In fixed mode `mask_i_set` pulses. In leveled mode `mask_lvl_wr` pulses, with `mask_lvl_nxt` equal to the accepted level, or 7 for the non-maskable request.
- R10: `ack_vec` equals `VEC_BASE + 4*(SRC_VEC_FIRST + ack_id)` for a maskable source, or `VEC_BASE + 4*NMI_VEC_NUM` for the non-maskable request. The defaults are 0x100, 16 and 7.
- R11: A source that loses arbitration but keeps its request asserted is accepted at a later boundary, once the winner has withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | 0 = fixed order with one mask bit, 1 = programmable levels |
| src_req | input | N_SRC | Request lines of the maskable sources |
| src_en | input | N_SRC | Per-source enables |
| src_lvl | input | N_SRC*LVL_W | Packed per-source levels |
| nmi_req | input | 1 | Non-maskable request, edge-latched |
| mask_i | input | 1 | Current mask bit (fixed mode) |
| mask_lvl | input | LVL_W | Current mask threshold (leveled mode) |
| insn_done | input | 1 | Instruction-boundary strobe |
| ack | output | 1 | One-cycle accept pulse |
| ack_nmi | output | 1 | The accepted request is the non-maskable one |
| ack_id | output | ID_W | Index of the accepted source |
| ack_lvl | output | LVL_W+1 | Level of the accepted request (8 for the non-maskable one) |
| ack_vec | output | VEC_W | Vector-table address |
| mask_i_set | output | 1 | Pulse: the core sets its mask bit |
| mask_lvl_wr | output | 1 | Pulse: the core loads `mask_lvl_nxt` |
| mask_lvl_nxt | output | LVL_W | New mask level |

## Verification
The assertions assume that the core takes the mask update before it raises the next `insn_done`, and that each mask input is stable in the cycle in which a boundary is sampled. The assertions also assume that a source holds `src_req` until it is serviced. The directed tasks keep to these assumptions. They change requests, enables, levels and masks only on falling edges and only between boundaries. They strobe `insn_done` for a single cycle and pulse `nmi_req` at least one cycle before the boundary that should take it.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  // Byte address of a vector-table slot: base plus four bytes per entry.
  function automatic logic [31:0] vec_slot_addr(input logic [31:0] base,
                                                input logic [31:0] num);
    return base + (num << 2);
  endfunction

  // Mask level loaded after acceptance: the winner's level, saturated to the field width.
  function automatic logic [7:0] next_mask_level(input logic [7:0] won_lvl,
                                                 input logic [7:0] lvl_max);
    return (won_lvl > lvl_max) ? lvl_max : won_lvl;
  endfunction

endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3
) (
  input  logic                   mode_sel,
  input  logic                   mask_i,
  input  logic [LVL_W-1:0]       mask_lvl,
  input  logic [N_SRC-1:0]       src_req,
  input  logic [N_SRC-1:0]       src_en,
  input  logic [N_SRC*LVL_W-1:0] src_lvl,
  output logic [N_SRC-1:0]       elig
);

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic [LVL_W-1:0] lvl_g;
    logic             raised;
    logic             pass_mask;

    assign lvl_g     = src_lvl[g*LVL_W +: LVL_W];
    assign raised    = src_req[g] & src_en[g];
    assign pass_mask = mode_sel ? (lvl_g > mask_lvl) : ~mask_i;
    assign elig[g]   = raised & pass_mask;
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  localparam int ID_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_sel,
  input  logic [N_SRC-1:0]       elig,
  input  logic [N_SRC*LVL_W-1:0] src_lvl,
  output logic                   any_elig,
  output logic [ID_W-1:0]        pick_id,
  output logic [LVL_W-1:0]       pick_lvl
);

  logic [LVL_W-1:0] best_key;
  logic [ID_W-1:0]  best_id;

  // Scanning from the top index down with >= lets the lower index win ties.
  // In fixed mode every key is zero, so the lowest eligible index wins.
  always_comb begin
    best_key = '0;
    best_id  = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        if ((mode_sel ? src_lvl[i*LVL_W +: LVL_W] : '0) >= best_key) begin
          best_key = mode_sel ? src_lvl[i*LVL_W +: LVL_W] : '0;
          best_id  = ID_W'(i);
        end
      end
    end
  end

  assign any_elig = |elig;
  assign pick_id  = best_id;
  assign pick_lvl = src_lvl[best_id*LVL_W +: LVL_W];

  AST_PICK_IS_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    any_elig |-> elig[pick_id]); // R4

  AST_PICK_LOWEST_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (any_elig && !mode_sel) |-> ((elig & ((N_SRC'(1) << pick_id) - N_SRC'(1))) == '0)); // R4

endmodule

// File: rtl/irq_dual_mode_ctrl.sv
module irq_dual_mode_ctrl #(
  parameter int          N_SRC         = 8,
  parameter int          LVL_W         = 3,
  parameter int          VEC_W         = 16,
  parameter logic [31:0] VEC_BASE      = 32'h0000_0100,
  parameter int          SRC_VEC_FIRST = 16,
  parameter int          NMI_VEC_NUM   = 7,
  localparam int         ID_W          = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_sel,
  input  logic [N_SRC-1:0]       src_req,
  input  logic [N_SRC-1:0]       src_en,
  input  logic [N_SRC*LVL_W-1:0] src_lvl,
  input  logic                   nmi_req,
  input  logic                   mask_i,
  input  logic [LVL_W-1:0]       mask_lvl,
  input  logic                   insn_done,
  output logic                   ack,
  output logic                   ack_nmi,
  output logic [ID_W-1:0]        ack_id,
  output logic [LVL_W:0]         ack_lvl,
  output logic [VEC_W-1:0]       ack_vec,
  output logic                   mask_i_set,
  output logic                   mask_lvl_wr,
  output logic [LVL_W-1:0]       mask_lvl_nxt
);
  import irq_ctrl_pkg::*;

  localparam logic [LVL_W:0] NMI_LVL = LVL_W'(1) << LVL_W;
  localparam logic [7:0]     LVL_MAX = 8'((1 << LVL_W) - 1);

  // Named internal events.
  logic [N_SRC-1:0] elig;
  logic             any_elig;
  logic [ID_W-1:0]  pick_id;
  logic [LVL_W-1:0] pick_lvl;
  logic             nmi_req_q;
  logic             nmi_pend_q;
  logic             nmi_rise;
  logic             take_any;
  logic             take_nmi;
  logic [LVL_W:0]   won_lvl;
  logic [31:0]      won_vec_num;

  irq_qualify #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_qualify (
    .mode_sel (mode_sel),
    .mask_i   (mask_i),
    .mask_lvl (mask_lvl),
    .src_req  (src_req),
    .src_en   (src_en),
    .src_lvl  (src_lvl),
    .elig     (elig)
  );

  irq_pick #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .elig     (elig),
    .src_lvl  (src_lvl),
    .any_elig (any_elig),
    .pick_id  (pick_id),
    .pick_lvl (pick_lvl)
  );

  // Edge latch for the non-maskable request.
  assign nmi_rise = nmi_req & ~nmi_req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_req_q  <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      nmi_req_q  <= nmi_req;
      nmi_pend_q <= (nmi_pend_q & ~take_nmi) | nmi_rise;
    end
  end

  assign take_nmi    = insn_done & nmi_pend_q;
  assign take_any    = insn_done & (nmi_pend_q | any_elig);
  assign won_lvl     = nmi_pend_q ? NMI_LVL : {1'b0, pick_lvl};
  assign won_vec_num = nmi_pend_q ? 32'(NMI_VEC_NUM) : 32'(SRC_VEC_FIRST) + 32'(pick_id);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack          <= 1'b0;
      ack_nmi      <= 1'b0;
      ack_id       <= '0;
      ack_lvl      <= '0;
      ack_vec      <= '0;
      mask_i_set   <= 1'b0;
      mask_lvl_wr  <= 1'b0;
      mask_lvl_nxt <= '0;
    end else begin
      ack         <= take_any;
      mask_i_set  <= take_any & ~mode_sel;
      mask_lvl_wr <= take_any & mode_sel;
      if (take_any) begin
        ack_nmi      <= take_nmi;
        ack_id       <= take_nmi ? '0 : pick_id;
        ack_lvl      <= won_lvl;
        ack_vec      <= VEC_W'(vec_slot_addr(VEC_BASE, won_vec_num));
        mask_lvl_nxt <= LVL_W'(next_mask_level(8'(won_lvl), LVL_MAX));
      end else begin
        ack_nmi <= 1'b0;
      end
    end
  end

  AST_ACK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(insn_done)); // R8

  AST_ACK_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !$past(insn_done, 1) |-> 1'b0); // R8

  AST_ACK_SRC_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ack_nmi) |-> ((($past(src_en & src_req) >> ack_id) & N_SRC'(1)) != '0)); // R2

  AST_FIXED_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ack_nmi && !$past(mode_sel)) |-> !$past(mask_i)); // R3

  AST_LEVEL_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ack_nmi && $past(mode_sel)) |-> (ack_lvl > {1'b0, $past(mask_lvl)})); // R5

  AST_ONE_MASK_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (mask_i_set ^ mask_lvl_wr)); // R9

  AST_NO_STRAY_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> (!mask_i_set && !mask_lvl_wr && !ack_nmi)); // R1

  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && nmi_pend_q) |=> (ack && ack_nmi)); // R7

endmodule

// File: tb/irq_dual_mode_ctrl_bench.sv
module irq_dual_mode_ctrl_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         mode_sel;
  logic [N-1:0] src_req;
  logic [N-1:0] src_en;
  logic [23:0]  src_lvl;
  logic         nmi_req;
  logic         mask_i;
  logic [2:0]   mask_lvl;
  logic         insn_done;
  logic         ack;
  logic         ack_nmi;
  logic [2:0]   ack_id;
  logic [3:0]   ack_lvl;
  logic [15:0]  ack_vec;
  logic         mask_i_set;
  logic         mask_lvl_wr;
  logic [2:0]   mask_lvl_nxt;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_dual_mode_ctrl u_irq_dual_mode_ctrl (
    .clk (clk), .rst_n (rst_n), .mode_sel (mode_sel), .src_req (src_req),
    .src_en (src_en), .src_lvl (src_lvl), .nmi_req (nmi_req), .mask_i (mask_i),
    .mask_lvl (mask_lvl), .insn_done (insn_done), .ack (ack), .ack_nmi (ack_nmi),
    .ack_id (ack_id), .ack_lvl (ack_lvl), .ack_vec (ack_vec),
    .mask_i_set (mask_i_set), .mask_lvl_wr (mask_lvl_wr), .mask_lvl_nxt (mask_lvl_nxt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected vector: every slot is four bytes; the source slots start at entry 16 above 0x100.
  function automatic int src_vec(input int id);
    return 256 + (id + 16) * 4;
  endfunction

  task automatic boundary();
    @(negedge clk) insn_done = 1'b1;
    @(negedge clk) insn_done = 1'b0;
  endtask

  task automatic nmi_pulse();
    @(negedge clk) nmi_req = 1'b1;
    @(negedge clk) nmi_req = 1'b0;
  endtask

  task automatic set_lvl(input int idx, input int lvl);
    src_lvl[idx*3 +: 3] = 3'(lvl);
  endtask

  task automatic t_reset();
    chk("R1 ack after reset", int'(ack), 0);
    chk("R1 mask_i_set after reset", int'(mask_i_set), 0);
    chk("R1 mask_lvl_wr after reset", int'(mask_lvl_wr), 0);
  endtask

  task automatic t_fixed_order();
    mode_sel = 1'b0; mask_i = 1'b0; src_en = '1;
    set_lvl(5, 7);
    src_req = 8'b1010_0100;
    boundary();
    chk("R4 fixed lowest index", int'(ack_id), 2);
    chk("R8 ack pulse", int'(ack), 1);
    chk("R9 mask_i_set fixed", int'(mask_i_set), 1);
    chk("R9 no lvl write fixed", int'(mask_lvl_wr), 0);
    chk("R10 vector src2", int'(ack_vec), src_vec(2));
    @(negedge clk);
    chk("R8 single cycle", int'(ack), 0);
    src_req[2] = 1'b0;
    boundary();
    chk("R11 loser accepted later", int'(ack_id), 5);
    chk("R10 vector src5", int'(ack_vec), src_vec(5));
    src_req = '0;
  endtask

  task automatic t_fixed_mask();
    mode_sel = 1'b0; mask_i = 1'b1; src_en = '1; src_req = '1;
    boundary();
    chk("R3 masked no ack", int'(ack), 0);
    mask_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 no boundary no ack", int'(ack), 0);
    boundary();
    chk("R8 ack at boundary", int'(ack), 1);
    chk("R4 fixed index 0", int'(ack_id), 0);
    src_req = '0;
  endtask

  task automatic t_enable();
    mode_sel = 1'b0; mask_i = 1'b0;
    src_en = 8'h00; src_req = 8'h01;
    boundary();
    chk("R2 disabled ignored", int'(ack), 0);
    src_en = 8'hFE; src_req = 8'h03;
    boundary();
    chk("R2 disabled skipped", int'(ack_id), 1);
    src_req = '0; src_en = '1;
  endtask

  task automatic t_leveled();
    mode_sel = 1'b1; mask_i = 1'b1; mask_lvl = 3'd3;
    src_lvl = '0;
    set_lvl(0, 2); set_lvl(1, 5); set_lvl(2, 5); set_lvl(3, 7);
    src_en = 8'hF7; src_req = 8'h0F;
    boundary();
    chk("R5 mask_i ignored in leveled", int'(ack), 1);
    chk("R6 tie lowest index", int'(ack_id), 1);
    chk("R6 ack_lvl", int'(ack_lvl), 5);
    chk("R9 lvl write", int'(mask_lvl_wr), 1);
    chk("R9 fixed set absent", int'(mask_i_set), 0);
    chk("R9 next mask", int'(mask_lvl_nxt), 5);
    mask_lvl = 3'd5;
    boundary();
    chk("R5 equal level blocked", int'(ack), 0);
    mask_lvl = 3'd0; src_req = 8'h07; set_lvl(2, 6);
    boundary();
    chk("R6 highest level wins", int'(ack_id), 2);
    src_req = '0;
  endtask

  task automatic t_nmi();
    mode_sel = 1'b0; mask_i = 1'b1; src_req = 8'h01; src_en = '1;
    nmi_pulse();
    boundary();
    chk("R7 nmi through mask", int'(ack_nmi), 1);
    chk("R10 nmi vector", int'(ack_vec), 256 + 7 * 4);
    chk("R9 nmi sets mask bit", int'(mask_i_set), 1);
    boundary();
    chk("R7 one ack per edge", int'(ack), 0);
    mode_sel = 1'b1; mask_lvl = 3'd0; src_lvl = '0; set_lvl(0, 7);
    nmi_pulse();
    boundary();
    chk("R7 nmi beats level 7", int'(ack_nmi), 1);
    chk("R7 nmi level", int'(ack_lvl), 8);
    chk("R9 nmi next mask", int'(mask_lvl_nxt), 7);
    src_req = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_sel = 1'b0; src_req = '0; src_en = '0; src_lvl = '0;
    nmi_req = 1'b0; mask_i = 1'b0; mask_lvl = '0; insn_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fixed_order();
    t_fixed_mask();
    t_enable();
    t_leveled();
    t_nmi();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule